// File: doc/BRIEF.md
# Micro-Op Dispatch Throttle with Carry-Over

This block sits between instruction decode and the out-of-order back end and decides, in each clock cycle, whether the instruction on its input may be dispatched. An instruction carries a micro-op count and a two-bit kind field. A dispatch group has a fixed width. The group budget is refreshed by a cycle tick. An instruction is granted only if it fits the group budget and the reorder buffer, the rename temporaries and the scheduler queues all report room. Load and store instructions also need room in their own queues.

An instruction whose micro-op count is larger than the remaining budget may still go, but only when the budget is untouched, which is the start of a group. Its excess micro-ops are kept as a carry-over debt. That debt consumes the budget of the following ticks until it is paid. When an attempt is refused, one saturating counter per stall cause records the first check that failed. The tick also raises a retire strobe toward the reorder buffer. That strobe is produced before the group budget is refreshed.

The input is a valid/ready stream. `in_ready` is computed combinationally from the presented micro-op count, the kind and the resource flags. It is high only while `in_valid` is high. An instruction is transferred in a cycle where both are high. A refused instruction may be held or changed by the source, and a refusal changes no budget state.

Top module: `uop_dispatch_throttle`

## Requirements
- R1: After reset the group budget equals WIDTH, the carry-over debt is zero and all six stall counters read zero.
- R2: `in_ready` is high only when `in_valid` is high and every check passes; with `in_valid` low, `in_ready` is low.
- R3: The width check passes when the micro-op count is at most the remaining budget, or when the remaining budget equals WIDTH (group start), regardless of count.
- R4: A transfer subtracts its micro-op count from the budget; if the count exceeds the budget, the budget becomes zero and the excess is added to the carry-over debt.
- R5: On a tick the budget becomes zero if the debt is at least WIDTH, else WIDTH minus the debt; the debt then drops by WIDTH, saturating at zero.
- R6: A transfer in the same cycle as a tick is charged first, and the tick refresh then uses the resulting debt.
- R7: Checks are ordered: width group, reorder buffer (`rob_ok`), rename temporaries (`ren_ok`), scheduler queue (`sq_ok`), load queue, store queue; a refused valid cycle increments only the counter of the first failing check.
- R8: `in_kind` bit 0 set requires `ldq_ok`, bit 1 set requires `stq_ok` (both bits: both queues, load checked first); with `in_kind` = 2'b00 the load and store flags have no effect.
- R9: Each stall counter saturates at all ones.
- R10: `retire_step` is high exactly in the cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Dispatch-cycle boundary strobe |
| in_valid | input | 1 | Instruction present |
| in_uops | input | UOP_W | Micro-op count of the instruction |
| in_kind | input | 2 | Bit 0: load, bit 1: store |
| in_ready | output | 1 | Dispatch grant (transfer when valid and ready) |
| rob_ok | input | 1 | Reorder buffer has room |
| ren_ok | input | 1 | Rename temporaries available |
| sq_ok | input | 1 | Scheduler queue has room |
| ldq_ok | input | 1 | Load queue has room |
| stq_ok | input | 1 | Store queue has room |
| retire_step | output | 1 | Retire strobe to the reorder buffer |
| cnt_group | output | CNT_W | Stalls from the width group rule |
| cnt_rob | output | CNT_W | Stalls from the reorder buffer |
| cnt_ren | output | CNT_W | Stalls from rename temporaries |
| cnt_sq | output | CNT_W | Stalls from the scheduler queue |
| cnt_ldq | output | CNT_W | Stalls from the load queue |
| cnt_stq | output | CNT_W | Stalls from the store queue |

## Verification
The bench builds the block with WIDTH = 4, UOP_W = 4 and CNT_W = 4. With these values a single 10-micro-op instruction leaves a debt that spans two ticks, so both the zero-budget and the partial-budget refresh cases occur. The four-bit counters also let a short run of refused attempts drive a counter into saturation.

// File: rtl/uop_dispatch_pkg.sv
package uop_dispatch_pkg;

  // Stall causes, numbered in check priority order (1 = checked first)
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_GROUP = 3'd1,
    RSN_ROB   = 3'd2,
    RSN_REN   = 3'd3,
    RSN_SQ    = 3'd4,
    RSN_LDQ   = 3'd5,
    RSN_STQ   = 3'd6
  } stall_rsn_e;

  localparam int NUM_RSN        = 6;
  localparam int KIND_LOAD_BIT  = 0;
  localparam int KIND_STORE_BIT = 1;

endpackage

// File: rtl/udt_width_gate.sv
module udt_width_gate #(
  parameter int WIDTH = 4,
  parameter int UOP_W = 4,
  localparam int AVAIL_W = $clog2(WIDTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               take,
  input  logic [UOP_W-1:0]   uops,
  output logic               width_ok,
  output logic [AVAIL_W-1:0] avail_q,
  output logic [UOP_W-1:0]   carry_q
);

  localparam int CMP_W = ((AVAIL_W > UOP_W) ? AVAIL_W : UOP_W) + 1;
  localparam logic [CMP_W-1:0] WIDTH_X = CMP_W'(WIDTH);

  logic [CMP_W-1:0] uops_x, avail_x, carry_x;
  logic [CMP_W-1:0] avail_mid, carry_mid;
  logic [CMP_W-1:0] avail_nxt, carry_nxt;

  assign uops_x  = CMP_W'(uops);
  assign avail_x = CMP_W'(avail_q);
  assign carry_x = CMP_W'(carry_q);

  // Fits the remaining budget, or the group is still untouched
  assign width_ok = (uops_x <= avail_x) || (avail_x == WIDTH_X);

  // Charge the transfer first
  always_comb begin
    avail_mid = avail_x;
    carry_mid = carry_x;
    if (take) begin
      if (uops_x <= avail_x) begin
        avail_mid = avail_x - uops_x;
      end else begin
        avail_mid = '0;
        carry_mid = carry_x + (uops_x - avail_x);
      end
    end
  end

  // Then refresh on a tick, paying down the debt
  always_comb begin
    avail_nxt = avail_mid;
    carry_nxt = carry_mid;
    if (tick) begin
      if (carry_mid >= WIDTH_X) begin
        avail_nxt = '0;
        carry_nxt = carry_mid - WIDTH_X;
      end else begin
        avail_nxt = WIDTH_X - carry_mid;
        carry_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= AVAIL_W'(WIDTH);
      carry_q <= '0;
    end else begin
      avail_q <= AVAIL_W'(avail_nxt);
      carry_q <= UOP_W'(carry_nxt);
    end
  end

endmodule

// File: rtl/udt_check_chain.sv
module udt_check_chain
  import uop_dispatch_pkg::*;
(
  input  logic       in_valid,
  input  logic [1:0] kind,
  input  logic       width_ok,
  input  logic       rob_ok,
  input  logic       ren_ok,
  input  logic       sq_ok,
  input  logic       ldq_ok,
  input  logic       stq_ok,
  output logic       grant,
  output stall_rsn_e rsn
);

  logic need_ldq, need_stq;

  assign need_ldq = kind[KIND_LOAD_BIT];
  assign need_stq = kind[KIND_STORE_BIT];

  // First failing check wins
  always_comb begin
    rsn = RSN_NONE;
    if (!width_ok)               rsn = RSN_GROUP;
    else if (!rob_ok)            rsn = RSN_ROB;
    else if (!ren_ok)            rsn = RSN_REN;
    else if (!sq_ok)             rsn = RSN_SQ;
    else if (need_ldq && !ldq_ok) rsn = RSN_LDQ;
    else if (need_stq && !stq_ok) rsn = RSN_STQ;
  end

  assign grant = in_valid && (rsn == RSN_NONE);

endmodule

// File: rtl/udt_stall_counters.sv
module udt_stall_counters
  import uop_dispatch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            stalled,
  input  stall_rsn_e                      rsn,
  output logic [NUM_RSN-1:0][CNT_W-1:0]   cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM_RSN; g++) begin : g_cnt
    logic hit;
    assign hit = stalled && (rsn == stall_rsn_e'(3'(g + 1)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (hit && (cnt[g] != CNT_MAX)) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uop_dispatch_throttle.sv
module uop_dispatch_throttle
  import uop_dispatch_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int UOP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             in_valid,
  input  logic [UOP_W-1:0] in_uops,
  input  logic [1:0]       in_kind,
  output logic             in_ready,
  input  logic             rob_ok,
  input  logic             ren_ok,
  input  logic             sq_ok,
  input  logic             ldq_ok,
  input  logic             stq_ok,
  output logic             retire_step,
  output logic [CNT_W-1:0] cnt_group,
  output logic [CNT_W-1:0] cnt_rob,
  output logic [CNT_W-1:0] cnt_ren,
  output logic [CNT_W-1:0] cnt_sq,
  output logic [CNT_W-1:0] cnt_ldq,
  output logic [CNT_W-1:0] cnt_stq
);

  localparam int AVAIL_W = $clog2(WIDTH + 1);

  logic                          width_ok;
  logic                          grant;
  stall_rsn_e                    rsn;
  logic [AVAIL_W-1:0]            avail_q;
  logic [UOP_W-1:0]              carry_q;
  logic [NUM_RSN-1:0][CNT_W-1:0] cnt;

  // Retire step precedes the budget refresh of the same tick
  assign retire_step = tick;

  udt_width_gate #(.WIDTH(WIDTH), .UOP_W(UOP_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .take     (grant),
    .uops     (in_uops),
    .width_ok (width_ok),
    .avail_q  (avail_q),
    .carry_q  (carry_q)
  );

  udt_check_chain u_chain (
    .in_valid (in_valid),
    .kind     (in_kind),
    .width_ok (width_ok),
    .rob_ok   (rob_ok),
    .ren_ok   (ren_ok),
    .sq_ok    (sq_ok),
    .ldq_ok   (ldq_ok),
    .stq_ok   (stq_ok),
    .grant    (grant),
    .rsn      (rsn)
  );

  udt_stall_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .stalled (in_valid && !grant),
    .rsn     (rsn),
    .cnt     (cnt)
  );

  assign in_ready  = grant;
  assign cnt_group = cnt[0];
  assign cnt_rob   = cnt[1];
  assign cnt_ren   = cnt[2];
  assign cnt_sq    = cnt[3];
  assign cnt_ldq   = cnt[4];
  assign cnt_stq   = cnt[5];

endmodule

// File: rtl/uop_dispatch_throttle_chk.sv
module uop_dispatch_throttle_chk #(
  parameter int WIDTH   = 4,
  parameter int UOP_W   = 4,
  parameter int CNT_W   = 16,
  parameter int AVAIL_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               in_valid,
  input logic [UOP_W-1:0]   in_uops,
  input logic               in_ready,
  input logic               rob_ok,
  input logic               ren_ok,
  input logic               sq_ok,
  input logic               retire_step,
  input logic [CNT_W-1:0]   cnt_rob,
  input logic [CNT_W-1:0]   cnt_ren,
  input logic [AVAIL_W-1:0] avail_q,
  input logic [UOP_W-1:0]   carry_q
);

  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_valid && rob_ok && ren_ok && sq_ok));

  // R3
  group_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (32'(avail_q) != WIDTH) && (32'(in_uops) > 32'(avail_q))) |-> !in_ready);

  // R4
  debt_empties_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_q != '0) |-> (avail_q == '0));

  // R5
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(avail_q) <= WIDTH);

  // R7
  rob_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rob_ok) |=> $stable(cnt_ren));

  // R9
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cnt_rob >= $past(cnt_rob)));

  // R10
  retire_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_step == tick);

endmodule

bind uop_dispatch_throttle uop_dispatch_throttle_chk #(
  .WIDTH(WIDTH), .UOP_W(UOP_W), .CNT_W(CNT_W), .AVAIL_W($clog2(WIDTH + 1))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .in_valid    (in_valid),
  .in_uops     (in_uops),
  .in_ready    (in_ready),
  .rob_ok      (rob_ok),
  .ren_ok      (ren_ok),
  .sq_ok       (sq_ok),
  .retire_step (retire_step),
  .cnt_rob     (cnt_rob),
  .cnt_ren     (cnt_ren),
  .avail_q     (avail_q),
  .carry_q     (carry_q)
);

// File: tb/uop_dispatch_throttle_test.sv
`timescale 1ns/1ps
module uop_dispatch_throttle_test;

  localparam int WIDTH = 4;
  localparam int UOP_W = 4;
  localparam int CNT_W = 4;
  localparam int CMAX  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic in_valid = 1'b0;
  logic [UOP_W-1:0] in_uops = '0;
  logic [1:0] in_kind = 2'b00;
  logic in_ready;
  logic rob_ok = 1'b1, ren_ok = 1'b1, sq_ok = 1'b1, ldq_ok = 1'b1, stq_ok = 1'b1;
  logic retire_step;
  logic [CNT_W-1:0] cnt_group, cnt_rob, cnt_ren, cnt_sq, cnt_ldq, cnt_stq;

  int checks = 0;
  int errors = 0;
  int exp_cnt [6];

  always #4 clk = ~clk;

  uop_dispatch_throttle #(.WIDTH(WIDTH), .UOP_W(UOP_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .in_uops(in_uops), .in_kind(in_kind), .in_ready(in_ready),
    .rob_ok(rob_ok), .ren_ok(ren_ok), .sq_ok(sq_ok), .ldq_ok(ldq_ok),
    .stq_ok(stq_ok), .retire_step(retire_step),
    .cnt_group(cnt_group), .cnt_rob(cnt_rob), .cnt_ren(cnt_ren),
    .cnt_sq(cnt_sq), .cnt_ldq(cnt_ldq), .cnt_stq(cnt_stq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // oks = {rob, ren, sq, ldq, stq}; exp_rsn: -1 none, 0 group .. 5 store
  task automatic attempt(input int uops, input logic [1:0] kind, input logic tk,
                         input logic [4:0] oks, input int exp_rsn, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_uops = UOP_W'(uops); in_kind = kind; tick = tk;
    {rob_ok, ren_ok, sq_ok, ldq_ok, stq_ok} = oks;
    #1;
    check(req, int'(in_ready), (exp_rsn < 0) ? 1 : 0);
    if (exp_rsn >= 0 && exp_cnt[exp_rsn] < CMAX) exp_cnt[exp_rsn]++;
  endtask

  task automatic do_tick();
    @(negedge clk);
    in_valid = 1'b0; tick = 1'b1;
    {rob_ok, ren_ok, sq_ok, ldq_ok, stq_ok} = 5'b11111;
    #1;
    check("R10 retire on tick", int'(retire_step), 1);
    @(negedge clk);
    tick = 1'b0;
    #1;
    check("R10 retire idle", int'(retire_step), 0);
  endtask

  task automatic check_counters(input string req);
    @(negedge clk);
    in_valid = 1'b0; tick = 1'b0;
    #1;
    check({req, " group cnt"}, int'(cnt_group), exp_cnt[0]);
    check({req, " rob cnt"},   int'(cnt_rob),   exp_cnt[1]);
    check({req, " ren cnt"},   int'(cnt_ren),   exp_cnt[2]);
    check({req, " sq cnt"},    int'(cnt_sq),    exp_cnt[3]);
    check({req, " ldq cnt"},   int'(cnt_ldq),   exp_cnt[4]);
    check({req, " stq cnt"},   int'(cnt_stq),   exp_cnt[5]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) exp_cnt[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 no ready without valid", int'(in_ready), 0);
    check_counters("R1");
    attempt(4, 2'b00, 1'b0, 5'b11111, -1, "R1 full budget after reset");
    do_tick();
  endtask

  task automatic t_fill();
    attempt(2, 2'b00, 1'b0, 5'b11111, -1, "R4 first part");
    attempt(2, 2'b00, 1'b0, 5'b11111, -1, "R4 second part");
    attempt(1, 2'b00, 1'b0, 5'b11111, 0, "R3 budget spent");
    do_tick();
    attempt(1, 2'b00, 1'b0, 5'b11111, -1, "R5 refreshed");
    attempt(3, 2'b00, 1'b0, 5'b11111, -1, "R4 exact fit");
    do_tick();
    check_counters("R3 fill");
  endtask

  task automatic t_wide();
    attempt(10, 2'b00, 1'b0, 5'b11111, -1, "R3 wide at group start");
    attempt(1, 2'b00, 1'b0, 5'b11111, 0, "R4 debt blocks");
    do_tick();
    attempt(1, 2'b00, 1'b0, 5'b11111, 0, "R5 debt >= width gives zero");
    do_tick();
    attempt(2, 2'b00, 1'b0, 5'b11111, -1, "R5 partial budget");
    attempt(1, 2'b00, 1'b0, 5'b11111, 0, "R5 partial budget spent");
    do_tick();
    attempt(4, 2'b00, 1'b0, 5'b11111, -1, "R5 debt paid");
    do_tick();
    check_counters("R4 wide");
  endtask

  task automatic t_priority();
    attempt(1, 2'b00, 1'b0, 5'b00111, 1, "R7 rob before rename");
    attempt(1, 2'b00, 1'b0, 5'b10011, 2, "R7 rename before sq");
    attempt(1, 2'b01, 1'b0, 5'b11001, 3, "R7 sq before ldq");
    attempt(1, 2'b01, 1'b0, 5'b11101, 4, "R8 load needs ldq");
    attempt(1, 2'b10, 1'b0, 5'b11110, 5, "R8 store needs stq");
    attempt(1, 2'b11, 1'b0, 5'b11100, 4, "R7 ldq before stq");
    attempt(1, 2'b00, 1'b0, 5'b11100, -1, "R8 plain ignores ldq stq");
    attempt(3, 2'b00, 1'b0, 5'b11111, -1, "R2 refusals kept budget");
    attempt(1, 2'b00, 1'b0, 5'b01111, 0, "R7 group before rob");
    do_tick();
    check_counters("R7");
  endtask

  task automatic t_same_cycle();
    attempt(6, 2'b00, 1'b1, 5'b11111, -1, "R6 wide with tick");
    attempt(2, 2'b00, 1'b0, 5'b11111, -1, "R6 budget after charge");
    attempt(1, 2'b00, 1'b0, 5'b11111, 0, "R6 budget spent");
    do_tick();
    check_counters("R6");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++)
      attempt(1, 2'b00, 1'b0, 5'b01111, 1, "R9 rob stall");
    check_counters("R9");
    check("R9 rob saturated", int'(cnt_rob), CMAX);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_wide();
    t_priority();
    t_same_cycle();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule